// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a core's retire stage and its private data cache. Retired stores are queued in a small FIFO so that the core does not wait for them to become visible to other cores. The queue writes its entries into the cache one at a time, oldest first. An entry is written only while the coherence controller reports that the core holds the target line with write ownership.

Loads are looked up against the queue in the same cycle. If the youngest queued store that touches any of the load's bytes covers all of them, the load takes its data from the queue. If that store covers only some of the bytes, the load waits. If no queued store touches the load's bytes, the load goes straight to the cache, ahead of any older queued stores. This is the store-then-load reordering that the design permits.

A fence pulse makes later loads wait until every store accepted up to and including the fence cycle has been written to the cache. Stores accepted after the fence do not lengthen that wait. Addresses are word addresses, and each store and load carries a byte-lane mask with one bit per byte (bit b covers data bits 8b+7..8b).

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `own_req` and `wr_valid` are 0, and a load is not stalled.
- R2: A store is accepted in a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly while DEPTH entries are held. A store offered while `st_ready` is 0 is dropped.
- R3: Queued stores are presented on `wr_addr`/`wr_data`/`wr_mask` strictly in acceptance order, with unchanged values. The oldest entry leaves the queue in a cycle where `wr_valid` and `wr_ready` are both 1.
- R4: `own_req` is 1 whenever the queue is non-empty, and `own_addr` then names the oldest entry's address. `wr_valid` is 1 only when the queue is non-empty and `own_grant` is 1.
- R5: A load is forwarded when the youngest queued entry that has the same address and shares at least one byte lane with the load covers every lane of `ld_mask`. Queued entries means those accepted in earlier cycles. When forwarded, `ld_fwd`=1 and `ld_done`=1, and `ld_data` carries that entry's bytes in the load's lanes with 0 in the other lanes. No cache read is issued.
- R6: When several queued entries qualify under R5, the youngest one supplies the data. An entry with the same address and no shared lane is skipped.
- R7: When the youngest entry that qualifies under R5 does not cover every load lane, `ld_stall`=1, and `ld_fwd`, `cr_valid` and `ld_done` are 0.
- R8: A load with no entry that qualifies under R5 asserts `cr_valid`, with `cr_addr`/`cr_mask` equal to the load, whatever older stores are queued. Its `ld_done` equals `cr_ready`.
- R9: After `fence` is 1 in cycle t, every load from cycle t+1 stalls (`ld_stall`=1, no forward, no cache read). The stall lasts until all stores accepted in cycles up to and including t have been written to the cache. Stores accepted after t do not prolong it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Retired store offered |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte lanes |
| ld_valid | input | 1 | Load presented |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte lanes |
| ld_done | output | 1 | Load completes this cycle |
| ld_fwd | output | 1 | Load served from the queue |
| ld_data | output | DW | Forwarded data, valid with ld_fwd |
| ld_stall | output | 1 | Load must wait |
| cr_valid | output | 1 | Load sent to cache |
| cr_addr | output | AW | Cache read address |
| cr_mask | output | DW/8 | Cache read byte lanes |
| cr_ready | input | 1 | Cache accepts the read |
| own_req | output | 1 | Write ownership wanted for own_addr |
| own_addr | output | AW | Address of the oldest queued store |
| own_grant | input | 1 | Line at own_addr is held with write ownership |
| wr_valid | output | 1 | Oldest store offered to cache |
| wr_addr | output | AW | Cache write address |
| wr_data | output | DW | Cache write data |
| wr_mask | output | DW/8 | Cache write byte lanes |
| wr_ready | input | 1 | Cache accepts the write |
| fence | input | 1 | Order later loads after all earlier stores |

## Verification
Directed loads are aimed at one address under several mask shapes. An exact-lane match against the youngest store, a lane set touched only by an older store, and a superset of the youngest store's lanes tell forwarding, youngest selection and the partial-overlap stall apart. A load to an unrelated address with stores still queued and ownership withheld shows the reordering. A fence taken together with a same-cycle store, followed by a store after it, shows which stores the fence waits for. A long random phase then runs over a four-word address space with random masks, grants and ready signals, compared on every cycle against a queue model, so that overlaps, a full queue and fences mix freely.

// File: rtl/sb_pkg.sv
// Shared types for the store buffer.
package sb_pkg;
    // Outcome of looking a load up against the queued stores.
    typedef enum logic [1:0] {
        LD_MISS    = 2'd0,
        LD_FWD     = 2'd1,
        LD_PARTIAL = 2'd2
    } ld_kind_e;
endpackage

// File: rtl/sb_queue.sv
// sb_queue: circular storage for queued stores.
// The entries are presented oldest-first on the ord_* outputs, and ord_valid marks which of them are live.
// Assumes the caller never pushes when full and never pops when empty.
module sb_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int MW    = DW / 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic [MW-1:0]              push_mask,
    input  logic                       pop,
    output logic [CW-1:0]              count,
    output logic [DEPTH-1:0]           ord_valid,
    output logic [DEPTH-1:0][AW-1:0]   ord_addr,
    output logic [DEPTH-1:0][DW-1:0]   ord_data,
    output logic [DEPTH-1:0][MW-1:0]   ord_mask
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [MW-1:0] mask_mem [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming store into the slot at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[tail_q] <= push_addr;
            data_mem[tail_q] <= push_data;
            mask_mem[tail_q] <= push_mask;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= wrap_inc(tail_q);
            if (pop)  head_q <= wrap_inc(head_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign count = count_q;

    // Present the entries oldest-first, rotated by the head pointer.
    for (genvar k = 0; k < DEPTH; k++) begin : g_ord
        logic [PW:0]   sum;
        logic [PW-1:0] idx;
        // Map age position k to a physical slot.
        always_comb begin
            sum = {1'b0, head_q} + (PW+1)'(k);
            idx = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : PW'(sum);
        end
        assign ord_valid[k] = (CW'(k) < count_q);
        assign ord_addr[k]  = addr_mem[idx];
        assign ord_data[k]  = data_mem[idx];
        assign ord_mask[k]  = mask_mem[idx];
    end

    // R2: the queue never takes a store beyond its depth.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q < CW'(DEPTH)));

    // R3: the queue never releases an entry it does not hold.
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count_q != '0));
endmodule

// File: rtl/sb_fwd.sv
// sb_fwd: compares a load with the queued stores.
// It finds the youngest entry with the same address that shares a byte lane with the load.
// It reports a miss, a full forward, or a partial overlap, and supplies that entry's bytes in the load's lanes.
// Purely combinational. Assumes the ord_* inputs are ordered oldest-first.
module sb_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int MW    = DW / 8
) (
    input  logic [AW-1:0]              ld_addr,
    input  logic [MW-1:0]              ld_mask,
    input  logic [DEPTH-1:0]           ord_valid,
    input  logic [DEPTH-1:0][AW-1:0]   ord_addr,
    input  logic [DEPTH-1:0][DW-1:0]   ord_data,
    input  logic [DEPTH-1:0][MW-1:0]   ord_mask,
    output sb_pkg::ld_kind_e           kind,
    output logic [DW-1:0]              fwd_data
);
    logic          found;
    logic [MW-1:0] sel_mask;
    logic [DW-1:0] sel_data;

    // Scan oldest to youngest, so the last hit is the youngest one.
    always_comb begin
        found    = 1'b0;
        sel_mask = '0;
        sel_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ord_valid[k] && (ord_addr[k] == ld_addr) && ((ord_mask[k] & ld_mask) != '0)) begin
                found    = 1'b1;
                sel_mask = ord_mask[k];
                sel_data = ord_data[k];
            end
        end
    end

    // Classify the lookup.
    always_comb begin
        if (!found)
            kind = sb_pkg::LD_MISS;
        else if ((sel_mask & ld_mask) == ld_mask)
            kind = sb_pkg::LD_FWD;
        else
            kind = sb_pkg::LD_PARTIAL;
    end

    // Keep only the lanes the load asked for.
    for (genvar b = 0; b < MW; b++) begin : g_lane
        assign fwd_data[8*b +: 8] = ld_mask[b] ? sel_data[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/sb_drain.sv
// sb_drain: releases the oldest entry to the cache while write ownership is held, and tracks how many queued entries a fence still waits for.
// Assumes own_grant refers to the line of the oldest entry.
module sb_drain #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          push,
    input  logic          own_grant,
    input  logic          wr_ready,
    input  logic          fence,
    output logic          wr_valid,
    output logic          pop,
    output logic          fence_block
);
    logic [CW-1:0] fence_left_q;

    assign wr_valid = (count != '0) && own_grant;
    assign pop      = wr_valid && wr_ready;

    // Load the fence window with every store accepted so far, then count it down as stores drain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fence_left_q <= '0;
        else if (fence)
            fence_left_q <= count + CW'(push) - CW'(pop);
        else if (pop && (fence_left_q != '0))
            fence_left_q <= fence_left_q - 1'b1;
    end

    assign fence_block = (fence_left_q != '0);

    // R4: an entry leaves only while ownership is granted.
    a_r4_drain_owned: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> own_grant);

    // R9: the fence never waits on more entries than the queue holds.
    a_r9_fence_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fence_left_q <= count);
endmodule

// File: rtl/sb_store_buffer.sv
// sb_store_buffer: store queue between the retire stage and the private data cache.
// Stores drain oldest-first under coherence write ownership. Loads forward from the queue, stall on a partial overlap, or bypass to the cache.
// A fence holds later loads until the earlier stores have drained.
// Assumes that the cache and the coherence controller hold their inputs stable for as long as they are asserted.
module sb_store_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [AW-1:0]     st_addr,
    input  logic [DW-1:0]     st_data,
    input  logic [DW/8-1:0]   st_mask,
    input  logic              ld_valid,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DW/8-1:0]   ld_mask,
    output logic              ld_done,
    output logic              ld_fwd,
    output logic [DW-1:0]     ld_data,
    output logic              ld_stall,
    output logic              cr_valid,
    output logic [AW-1:0]     cr_addr,
    output logic [DW/8-1:0]   cr_mask,
    input  logic              cr_ready,
    output logic              own_req,
    output logic [AW-1:0]     own_addr,
    input  logic              own_grant,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [DW/8-1:0]   wr_mask,
    input  logic              wr_ready,
    input  logic              fence
);
    localparam int MW = DW / 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]            count;
    logic                     push, pop, fence_block;
    logic [DEPTH-1:0]         ord_valid;
    logic [DEPTH-1:0][AW-1:0] ord_addr;
    logic [DEPTH-1:0][DW-1:0] ord_data;
    logic [DEPTH-1:0][MW-1:0] ord_mask;
    sb_pkg::ld_kind_e         kind;

    assign st_ready = (count < CW'(DEPTH));
    assign push     = st_valid && st_ready;

    sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW), .CW(CW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data), .push_mask(st_mask),
        .pop(pop), .count(count),
        .ord_valid(ord_valid), .ord_addr(ord_addr), .ord_data(ord_data), .ord_mask(ord_mask)
    );

    sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW)) u_fwd (
        .ld_addr(ld_addr), .ld_mask(ld_mask),
        .ord_valid(ord_valid), .ord_addr(ord_addr), .ord_data(ord_data), .ord_mask(ord_mask),
        .kind(kind), .fwd_data(ld_data)
    );

    sb_drain #(.DEPTH(DEPTH), .CW(CW)) u_drain (
        .clk(clk), .rst_n(rst_n), .count(count), .push(push),
        .own_grant(own_grant), .wr_ready(wr_ready), .fence(fence),
        .wr_valid(wr_valid), .pop(pop), .fence_block(fence_block)
    );

    // The oldest entry drives both the ownership request and the write port.
    assign own_req  = (count != '0);
    assign own_addr = ord_addr[0];
    assign wr_addr  = ord_addr[0];
    assign wr_data  = ord_data[0];
    assign wr_mask  = ord_mask[0];

    // Steer the load to forward, stall or cache.
    assign ld_fwd   = ld_valid && !fence_block && (kind == sb_pkg::LD_FWD);
    assign ld_stall = ld_valid && (fence_block || (kind == sb_pkg::LD_PARTIAL));
    assign cr_valid = ld_valid && !fence_block && (kind == sb_pkg::LD_MISS);
    assign cr_addr  = ld_addr;
    assign cr_mask  = ld_mask;
    assign ld_done  = ld_fwd || (cr_valid && cr_ready);

    // R4: the oldest entry stays in place until it drains.
    a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && !pop) |=> (own_req && $stable(own_addr)));

    // R2: st_ready only drops after a store was offered.
    a_r2_ready_falls_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_ready) |-> $past(st_valid));

    // R9: a fence with two or more stores queued blocks the next load.
    a_r9_fence_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fence && (count >= CW'(2))) |=> (!cr_valid && !ld_fwd));

    // R5: a forwarded load never also reads the cache.
    a_r5_fwd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> (!cr_valid && !ld_stall));
endmodule

// File: tb/sb_store_buffer_test.sv
// Bench for sb_store_buffer: a behavioural queue model compared with the outputs on every cycle.
module sb_store_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  mask;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, cr_ready = 0, own_grant = 0, wr_ready = 0, fence = 0;
    logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
    logic [3:0]  st_mask = 0, ld_mask = 0;
    logic st_ready, ld_done, ld_fwd, ld_stall, cr_valid, own_req, wr_valid;
    logic [31:0] ld_data, cr_addr, own_addr, wr_addr, wr_data;
    logic [3:0]  cr_mask, wr_mask;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    ent_t q[$];
    int   fence_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_store_buffer #(.DEPTH(DEPTH), .AW(32), .DW(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mask(ld_mask),
        .ld_done(ld_done), .ld_fwd(ld_fwd), .ld_data(ld_data), .ld_stall(ld_stall),
        .cr_valid(cr_valid), .cr_addr(cr_addr), .cr_mask(cr_mask), .cr_ready(cr_ready),
        .own_req(own_req), .own_addr(own_addr), .own_grant(own_grant),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask), .wr_ready(wr_ready),
        .fence(fence)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Compare every output with the model, then advance the model by one clock.
    task automatic model_cycle();
        int n;
        bit exp_ready, exp_wv, pop, push, fblk, found, exp_fwd, exp_part, exp_cr;
        logic [3:0]  m;
        logic [31:0] d, ed;
        n = q.size();
        exp_ready = (n < DEPTH);
        exp_wv = (n > 0) && own_grant;
        pop = exp_wv && wr_ready;
        push = st_valid && exp_ready;
        fblk = (fence_left > 0);
        found = 0; m = 0; d = 0;
        for (int i = n - 1; i >= 0; i--) begin
            if (q[i].addr == ld_addr && (q[i].mask & ld_mask) != 0) begin
                found = 1; m = q[i].mask; d = q[i].data;
                break;
            end
        end
        exp_fwd  = ld_valid && !fblk && found && ((m & ld_mask) == ld_mask);
        exp_part = found && ((m & ld_mask) != ld_mask);
        exp_cr   = ld_valid && !fblk && !found;
        ed = 0;
        for (int b = 0; b < 4; b++) if (ld_mask[b]) ed[8*b +: 8] = d[8*b +: 8];

        chk("R2 st_ready", st_ready, exp_ready);
        chk("R4 own_req", own_req, n > 0);
        if (n > 0) chk("R4 own_addr", own_addr, q[0].addr);
        chk("R4 wr_valid", wr_valid, exp_wv);
        if (exp_wv) begin
            chk("R3 wr_addr", wr_addr, q[0].addr);
            chk("R3 wr_data", wr_data, q[0].data);
            chk("R3 wr_mask", wr_mask, q[0].mask);
        end
        chk("R5 ld_fwd", ld_fwd, exp_fwd);
        if (exp_fwd) chk("R6 ld_data", ld_data, ed);
        chk("R7/R9 ld_stall", ld_stall, ld_valid && (fblk || exp_part));
        chk("R8 cr_valid", cr_valid, exp_cr);
        if (exp_cr) chk("R8 cr_addr", {cr_mask, cr_addr}, {ld_mask, ld_addr});
        chk("R8 ld_done", ld_done, exp_fwd || (exp_cr && cr_ready));

        if (fence) fence_left = n + int'(push) - int'(pop);
        else if (pop && fence_left > 0) fence_left--;
        if (pop) void'(q.pop_front());
        if (push) q.push_back('{addr: st_addr, data: st_data, mask: st_mask});
    endtask

    task automatic tick();
        #1;
        model_cycle();
        @(negedge clk);
    endtask

    task automatic idle();
        st_valid = 0; ld_valid = 0; fence = 0;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] dt, input logic [3:0] mk);
        st_valid = 1; st_addr = a; st_data = dt; st_mask = mk;
    endtask

    task automatic look(input logic [31:0] a, input logic [3:0] mk);
        ld_valid = 1; ld_addr = a; ld_mask = mk;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: empty after reset
        look(32'd0, 4'hf); cr_ready = 1;
        #1;
        chk("R1 st_ready", st_ready, 1);
        chk("R1 own_req", own_req, 0);
        chk("R1 wr_valid", wr_valid, 0);
        chk("R1 ld_stall", ld_stall, 0);
        tick();

        idle(); own_grant = 0;
        put(32'd5, 32'h11111111, 4'hf); tick();
        put(32'd5, 32'h22222222, 4'h3); tick();
        put(32'd9, 32'h33333333, 4'hf); look(32'd5, 4'h3);
        #1; chk("R6 youngest supplies data", ld_data, 32'h00002222);
        chk("R6 forward", ld_fwd, 1);
        tick();
        idle(); look(32'd5, 4'hc);
        #1; chk("R5 older full cover forwarded", {ld_fwd, ld_data}, {1'b1, 32'h11110000});
        tick();
        look(32'd5, 4'hf);
        #1; chk("R7 partial stalls", {ld_stall, cr_valid, ld_done}, 3'b100);
        tick();
        look(32'd7, 4'hf); cr_ready = 1;
        #1; chk("R8 bypass with stores queued", {cr_valid, ld_done, wr_valid}, 3'b110);
        tick();
        idle();
        for (int i = 0; i < 6; i++) begin
            put(32'd20 + i, 32'hA0 + i, 4'h1); tick();
        end
        put(32'd99, 32'h99, 4'hf);
        #1; chk("R2 full", st_ready, 0);
        tick();
        idle(); own_grant = 1; wr_ready = 1;
        #1; chk("R3 first drained", {wr_valid, wr_addr, wr_data}, {1'b1, 32'd5, 32'h11111111});
        tick();
        #1; chk("R3 second drained", {wr_addr, wr_data, wr_mask}, {32'd5, 32'h22222222, 4'h3});
        tick();
        while (q.size() > 0) tick();

        // Fence: the same-cycle store counts, the later store does not.
        own_grant = 0;
        put(32'd40, 32'h40, 4'hf); tick();
        put(32'd41, 32'h41, 4'hf); tick();
        put(32'd42, 32'h42, 4'hf); fence = 1; tick();
        idle(); look(32'd60, 4'hf);
        #1; chk("R9 load held after fence", {ld_stall, cr_valid}, 2'b10);
        tick();
        own_grant = 1; put(32'd43, 32'h43, 4'hf); tick();
        idle(); look(32'd60, 4'hf); tick();
        #1; chk("R9 held until last earlier store", ld_stall, 1);
        tick();
        own_grant = 0;
        #1; chk("R9 released, later store still queued", {cr_valid, own_req, own_addr}, {2'b11, 32'd43});
        tick();
        idle(); own_grant = 1;
        while (q.size() > 0) tick();

        // Random mix over a small address space.
        for (int c = 0; c < 4000; c++) begin
            st_valid = ($urandom % 2) == 0;
            st_addr = $urandom % 4; st_data = $urandom; st_mask = 4'($urandom % 15 + 1);
            ld_valid = ($urandom % 2) == 0;
            ld_addr = $urandom % 4; ld_mask = 4'($urandom % 15 + 1);
            cr_ready = ($urandom % 2) == 0;
            own_grant = ($urandom % 4) != 0;
            wr_ready = ($urandom % 3) != 0;
            fence = ($urandom % 16) == 0;
            tick();
        end
        idle(); own_grant = 1; wr_ready = 1;
        while (q.size() > 0) tick();
        tick();
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule